// File: doc/BRIEF.md
# SPI Mode-0 Serial Master with Inter-Word Select Pulsing

This block is a synchronous serial master that works only with clock polarity 0 and phase 0. Words enter through a small transmit FIFO on a valid/ready stream. Each word is shifted out on `mosi` most significant bit first. The word received on `miso` at the same time is pushed into a receive FIFO, which the consumer drains through a second valid/ready stream. The block drives the active-low select `ssel_n` and the serial clock `sclk`. It also drives `sclk_oe_n`, an active-low output enable for the clock pad.

The serial clock half-period is `max(divider,1)+1` system clocks. The word length is set by `word_len`. Words that wait in the FIFO are sent back to back. Between them, select goes high for one full serial clock period, because in phase 0 a slave may only load new data while it is deselected.

Back-pressure rules: `tx_ready` is low while the transmit FIFO is full, and a word is taken only in a cycle where `tx_valid` and `tx_ready` are both high. The serial side cannot stall. If a received word finds the receive FIFO full, that word is lost and the sticky `overrun` flag is raised. While `rx_valid` is high and `rx_ready` is low, `rx_data` does not change.

Top module: `spi_m0_master`

## Requirements
- R1: While no word is in flight (including after reset), `ssel_n` is 1, `sclk` is 0 and `mosi` is 0.
- R2: A word starts, with `ssel_n` falling, only when `enable` is 1 and the transmit FIFO holds a word. While `enable` is 0, queued words wait and select stays high.
- R3: After `ssel_n` falls, `mosi` stays 0 and `sclk` stays 0 for one half-period H. `mosi` then shows the MSB for a further H, after which `sclk` rises.
- R4: Each bit is held on `mosi` for a low half-period, then a high half-period of `sclk`. `miso` is sampled on the rising edge. Bits go out MSB first and change only as `sclk` falls.
- R5: The word length is `word_len+1` bits. Any `word_len` value below 3 gives 4 bits. Only the low bits of `tx_data` are sent.
- R6: After the last rising edge, `sclk` falls after H. `ssel_n` rises H later, so it rises one full period (2H) after the last sample, and `mosi` returns to 0.
- R7: If `enable` is 1 and another word is queued when a word ends, `ssel_n` stays high for exactly 2H. The next word then starts with the R3 sequence.
- R8: Each received word is offered on `rx_data`, right-aligned with zeros above the word, in arrival order.
- R9: A word received while the receive FIFO is full is dropped. `overrun` is then set and stays 1 until reset.
- R10: One cycle after `is_master` is sampled, `sclk_oe_n` equals its inverse. It is 1 during reset.
- R11: H equals `divider+1` system clocks. A `divider` of 0 behaves as 1.
- R12: `tx_ready` is 1 after reset and 0 while the transmit FIFO (depth 4) is full.
- R13: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` stays 1 and `rx_data` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows words to start |
| is_master | input | 1 | 1 = master configuration (affects only the pad enable) |
| divider | input | 8 | Half-period count minus one (0 acts as 1) |
| word_len | input | 4 | Word length minus one (values below 3 act as 3) |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit FIFO has room |
| tx_data | input | 16 | Transmit word, right-aligned |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 16 | Received word, right-aligned |
| overrun | output | 1 | Sticky: a received word was dropped |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, idles low |
| ssel_n | output | 1 | Active-low frame/select |
| mosi | output | 1 | Serial data to the slave |
| sclk_oe_n | output | 1 | Active-low clock pad output enable |

## Verification
The assertions check, on every cycle, the invariants that hold at any moment:
- the idle levels whenever select is high;
- clean pin levels at the moment select falls;
- that `mosi` holds still while `sclk` is high;
- that the inter-word gap lasts more than one cycle;
- that the overrun flag is sticky and a stalled receive word is held;
- that the pad enable follows the configuration bit.

The exact half-period counts can only be shown by the bench's scenarios, which compare the pins on every cycle with a behavioural timing model. These cover the R3 lead-in, the 2H tail and the exact 2H gap, under several dividers and word lengths. The scenarios also show that words wait while the block is disabled, that received data appears in order, and that a word is dropped when the receive FIFO is full.

// File: rtl/spi_m0_pkg.sv
package spi_m0_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_LOW,
    PH_HIGH,
    PH_TAIL,
    PH_GAP0,
    PH_GAP1
  } phase_e;
endpackage

// File: rtl/spi_m0_fifo.sv
module spi_m0_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         full, empty;

  assign empty     = (wp == rp);
  assign full      = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (in_valid && !full)    wp <= wp + (AW+1)'(1);
      if (out_ready && !empty)  rp <= rp + (AW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && !full) mem[wp[AW-1:0]] <= in_data;
  end
endmodule

// File: rtl/spi_m0_halfclk.sv
module spi_m0_halfclk #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;
  logic [DW-1:0] limit;

  assign limit = (div == '0) ? DW'(1) : div;
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + DW'(1);
  end
endmodule

// File: rtl/spi_m0_engine.sv
module spi_m0_engine
  import spi_m0_pkg::*;
#(
  parameter int WMAX = 16,
  parameter int LW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [LW-1:0]   word_len,
  input  logic            tick,
  output logic            run,
  input  logic            tx_valid,
  input  logic [WMAX-1:0] tx_data,
  output logic            tx_pop,
  input  logic            miso,
  output logic            sclk,
  output logic            ssel_n,
  output logic            mosi,
  output logic            rx_push,
  output logic [WMAX-1:0] rx_word,
  input  logic            rx_space,
  output logic            overrun
);
  localparam int CW = $clog2(WMAX + 1);

  phase_e          ph;
  logic [WMAX-1:0] sh_tx, sh_rx, aligned;
  logic [CW-1:0]   left, nbits;
  logic            start_ok;

  always_comb begin
    if (word_len < LW'(3)) nbits = CW'(4);
    else                   nbits = CW'(word_len) + CW'(1);
  end

  assign aligned  = tx_data << (CW'(WMAX) - nbits);
  assign start_ok = enable && tx_valid;
  assign run      = (ph != PH_IDLE);
  assign tx_pop   = start_ok && ((ph == PH_IDLE) || (ph == PH_GAP1 && tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      sclk    <= 1'b0;
      ssel_n  <= 1'b1;
      mosi    <= 1'b0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      left    <= '0;
      rx_push <= 1'b0;
      rx_word <= '0;
      overrun <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      if (rx_push && !rx_space) overrun <= 1'b1;
      if (tx_pop) begin
        ssel_n <= 1'b0;
        mosi   <= 1'b0;
        sh_tx  <= aligned;
        sh_rx  <= '0;
        left   <= nbits;
        ph     <= PH_LEAD;
      end else if (tick) begin
        case (ph)
          PH_LEAD: begin
            mosi  <= sh_tx[WMAX-1];
            sh_tx <= {sh_tx[WMAX-2:0], 1'b0};
            ph    <= PH_LOW;
          end
          PH_LOW: begin
            sclk  <= 1'b1;
            sh_rx <= {sh_rx[WMAX-2:0], miso};
            left  <= left - CW'(1);
            ph    <= PH_HIGH;
          end
          PH_HIGH: begin
            sclk <= 1'b0;
            if (left == '0) begin
              rx_push <= 1'b1;
              rx_word <= sh_rx;
              ph      <= PH_TAIL;
            end else begin
              mosi  <= sh_tx[WMAX-1];
              sh_tx <= {sh_tx[WMAX-2:0], 1'b0};
              ph    <= PH_LOW;
            end
          end
          PH_TAIL: begin
            ssel_n <= 1'b1;
            mosi   <= 1'b0;
            ph     <= start_ok ? PH_GAP0 : PH_IDLE;
          end
          PH_GAP0: ph <= PH_GAP1;
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_m0_master.sv
module spi_m0_master #(
  parameter int WORD_MAX = 16,
  parameter int DIV_W    = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 2,
  parameter int LEN_W    = $clog2(WORD_MAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                is_master,
  input  logic [DIV_W-1:0]    divider,
  input  logic [LEN_W-1:0]    word_len,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [WORD_MAX-1:0] tx_data,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic [WORD_MAX-1:0] rx_data,
  output logic                overrun,
  input  logic                miso,
  output logic                sclk,
  output logic                ssel_n,
  output logic                mosi,
  output logic                sclk_oe_n
);
  logic                q_valid, q_pop, run, tick, rx_push, rx_space;
  logic [WORD_MAX-1:0] q_data, rx_word;

  spi_m0_fifo #(.W(WORD_MAX), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(q_valid), .out_ready(q_pop), .out_data(q_data)
  );

  spi_m0_halfclk #(.DW(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .div(divider), .tick(tick)
  );

  spi_m0_engine #(.WMAX(WORD_MAX), .LW(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .enable(enable), .word_len(word_len),
    .tick(tick), .run(run),
    .tx_valid(q_valid), .tx_data(q_data), .tx_pop(q_pop),
    .miso(miso), .sclk(sclk), .ssel_n(ssel_n), .mosi(mosi),
    .rx_push(rx_push), .rx_word(rx_word), .rx_space(rx_space),
    .overrun(overrun)
  );

  spi_m0_fifo #(.W(WORD_MAX), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_push), .in_ready(rx_space), .in_data(rx_word),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_oe_n <= 1'b1;
    else        sclk_oe_n <= !is_master;
  end
endmodule

// File: rtl/spi_m0_checker.sv
module spi_m0_checker #(
  parameter int WORD_MAX = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic                is_master,
  input logic                rx_valid,
  input logic                rx_ready,
  input logic [WORD_MAX-1:0] rx_data,
  input logic                overrun,
  input logic                sclk,
  input logic                ssel_n,
  input logic                mosi,
  input logic                sclk_oe_n
);
  a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    ssel_n |-> (!sclk && !mosi));

  a_r2_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssel_n) |-> $past(enable));

  a_r3_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssel_n) |-> (!sclk && !mosi));

  a_r4_rise_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !ssel_n);

  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r7_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssel_n) |=> ssel_n);

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r10_pad_enable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sclk_oe_n == !$past(is_master)));

  a_r13_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind spi_m0_master spi_m0_checker #(.WORD_MAX(WORD_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .is_master(is_master),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .overrun(overrun), .sclk(sclk), .ssel_n(ssel_n), .mosi(mosi),
  .sclk_oe_n(sclk_oe_n)
);

// File: tb/tb_spi_m0_master.sv
module tb_spi_m0_master;
  logic        clk = 1'b0;
  logic        rst_n, enable, is_master, tx_valid, rx_ready, miso;
  logic [7:0]  divider;
  logic [3:0]  word_len;
  logic [15:0] tx_data;
  logic        tx_ready, rx_valid, overrun, sclk, ssel_n, mosi, sclk_oe_n;
  logic [15:0] rx_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] txq[$];
  logic [15:0] slq[$];
  logic [15:0] rxq[$];

  always #4 clk = ~clk;

  spi_m0_master dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .is_master(is_master),
    .divider(divider), .word_len(word_len),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .overrun(overrun), .miso(miso), .sclk(sclk), .ssel_n(ssel_n),
    .mosi(mosi), .sclk_oe_n(sclk_oe_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int half_p();
    return ((divider == 8'd0) ? 1 : int'(divider)) + 1;
  endfunction

  function automatic int nbits();
    return (word_len < 4'd3) ? 4 : int'(word_len) + 1;
  endfunction

  task automatic pins(input string req, input logic es, input logic ec, input logic em);
    chk(req, {29'b0, ssel_n, sclk, mosi}, {29'b0, es, ec, em});
  endtask

  task automatic hold(input string req, input int n, input logic es, input logic ec, input logic em);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pins(req, es, ec, em);
    end
  endtask

  // Behavioural timing model of one word; entered at the first sample with select low.
  task automatic do_frame();
    int h, nb;
    logic [15:0] w, s;
    h = half_p();
    nb = nbits();
    w = txq.pop_front();
    s = slq.pop_front();
    pins("R3", 1'b0, 1'b0, 1'b0);
    hold("R3", h - 1, 1'b0, 1'b0, 1'b0);
    for (int b = nb - 1; b >= 0; b--) begin
      @(negedge clk);
      miso = s[b];
      pins("R4", 1'b0, 1'b0, w[b]);
      hold("R4", h - 1, 1'b0, 1'b0, w[b]);
      hold("R4", h, 1'b0, 1'b1, w[b]);
    end
    rxq.push_back(s & 16'((1 << nb) - 1));
    hold("R6", h, 1'b0, 1'b0, w[0]);
  endtask

  initial begin : model
    bit more;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (ssel_n) begin
        pins("R1", 1'b1, 1'b0, 1'b0);
      end else begin
        chk("R2 start needs queued word", 32'(txq.size() != 0), 32'd1);
        if (txq.size() != 0) begin
          do_frame();
          more = 1'b1;
          while (more) begin
            more = (txq.size() != 0) && enable;
            if (more) begin
              hold("R7", 2 * half_p(), 1'b1, 1'b0, 1'b0);
              @(negedge clk);
              chk("R7 next word starts after 2H", 32'(ssel_n), 32'd0);
              if (ssel_n) more = 1'b0;
              else        do_frame();
            end else begin
              hold("R6", 1, 1'b1, 1'b0, 1'b0);
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (rxq.size() == 0) chk("R8 unexpected rx word", 32'(rx_data), 32'hFFFF_FFFF);
      else                 chk("R8", 32'(rx_data), 32'(rxq.pop_front()));
    end
  end

  task automatic push_word(input logic [15:0] w, input logic [15:0] s);
    @(posedge clk); #1;
    tx_valid = 1'b1;
    tx_data  = w;
    forever begin
      @(negedge clk);
      if (tx_ready) break;
    end
    txq.push_back(w);
    slq.push_back(s);
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(posedge clk); #1;
    enable = v;
  endtask

  task automatic wait_done();
    forever begin
      @(negedge clk);
      if (txq.size() == 0) break;
    end
    repeat ((2 * nbits() + 8) * half_p() + 10) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    logic [15:0] held;
    rst_n = 1'b0; enable = 1'b0; is_master = 1'b0; divider = 8'd1;
    word_len = 4'd7; tx_valid = 1'b0; tx_data = '0; rx_ready = 1'b1; miso = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ssel_n", 32'(ssel_n), 32'd1);
    chk("R1 reset sclk", 32'(sclk), 32'd0);
    chk("R12 reset tx_ready", 32'(tx_ready), 32'd1);
    chk("R8 reset rx_valid", 32'(rx_valid), 32'd0);
    chk("R9 reset overrun", 32'(overrun), 32'd0);
    chk("R10 reset pad enable", 32'(sclk_oe_n), 32'd1);

    // R10: pad enable follows the configuration bit
    @(posedge clk); #1 is_master = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 master", 32'(sclk_oe_n), 32'd0);
    @(posedge clk); #1 is_master = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 slave", 32'(sclk_oe_n), 32'd1);
    @(posedge clk); #1 is_master = 1'b1;

    // R2: a queued word waits while disabled
    push_word(16'h00A5, 16'h003C);
    repeat (40) @(negedge clk);
    chk("R2 disabled stays idle", 32'(ssel_n), 32'd1);
    set_en(1'b1);
    wait_done();

    // R7/R12/R11: 16-bit burst of four, divider 3
    set_en(1'b0);
    divider = 8'd3; word_len = 4'd15;
    push_word(16'h8001, 16'hBEEF);
    push_word(16'h7FFE, 16'h1234);
    push_word(16'hC35A, 16'h0F0F);
    push_word(16'h0000, 16'hFFFF);
    @(negedge clk);
    chk("R12 full fifo", 32'(tx_ready), 32'd0);
    set_en(1'b1);
    wait_done();

    // R11/R5: divider 0 acts as 1, 4-bit words
    set_en(1'b0);
    divider = 8'd0; word_len = 4'd3;
    push_word(16'h0009, 16'h0006);
    push_word(16'h0006, 16'h0009);
    set_en(1'b1);
    wait_done();

    // R5: word_len below 3 gives 4 bits, upper data bits ignored
    set_en(1'b0);
    divider = 8'd2; word_len = 4'd1;
    push_word(16'hFFF6, 16'hFFFB);
    set_en(1'b1);
    wait_done();

    // R9/R13: receive FIFO full drops the third word
    set_en(1'b0);
    divider = 8'd1; word_len = 4'd7;
    rx_ready = 1'b0;
    push_word(16'h0011, 16'h00A1);
    push_word(16'h0022, 16'h00B2);
    push_word(16'h0033, 16'h00C3);
    set_en(1'b1);
    wait_done();
    chk("R9 overrun set", 32'(overrun), 32'd1);
    chk("R13 rx_valid while stalled", 32'(rx_valid), 32'd1);
    held = rx_data;
    repeat (5) @(negedge clk);
    chk("R13 rx_data held", 32'(rx_data), 32'(held));
    @(posedge clk); #1 rx_ready = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 one word dropped", 32'(rxq.size()), 32'd1);
    chk("R9 dropped word value", 32'(rxq[0]), 32'h00C3);
    rxq.delete();
    chk("R9 overrun sticky", 32'(overrun), 32'd1);
    chk("R8 rx drained", 32'(rx_valid), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule